// File: doc/BRIEF.md
# Spread-Spectrum Triangle Offset Generator

This block produces the modulation trajectory for a spread-spectrum clock. A fractional-N or digital synthesizer loop adds the signed output word, given in parts-per-million, to its nominal divide ratio. The output follows a triangle over time, which spreads the clock energy across a band. Two profiles are available. A centred profile swings equally above and below zero, so the long-term average equals the target. A downward profile keeps every point at or below zero, so the peak equals the target. The loop, oscillator and filter lie outside this block.

Three settings are sampled when the ramp starts: the profile, a 5-bit deviation code and a rate select. They are sampled again each time the triangle returns to its minimum, so a whole period always uses one setting. The half-period in system-clock ticks is `CLK_HZ / (2 * rate)`, using the slow or fast rate parameter. A Bresenham-style accumulator spreads the span over those ticks exactly. It uses per-code quotient and remainder values that are computed at elaboration. Every output that shares one instance sees the same deviation and the same rate.

Top module: `ssc_tri_gen`

## Requirements
- R1: While reset is high, and in the cycle after any clock edge that sees `en_i` low, `offset_o` is 0, `phase_up_o` is 0 and `wrap_o` is 0.
- R2: After the first edge with `en_i` high, following idle, `offset_o` equals the profile minimum. The ramp then starts rising from that point.
- R3: With `down_i` = 0 (centred), the minimum is −1250·k ppm and the maximum is +1250·k ppm, where k is the effective code.
- R4: With `down_i` = 1 (downward), the minimum is −2500·k ppm and the maximum is 0. The offset is never positive.
- R5: The effective code k is `dev_code_i` clamped to the range 1 to 16. A code of 0 acts as 1, and any code above 16 acts as 16.
- R6: Let S = 2500·k, let H = CLK_HZ/(2·rate), with the rate set by `fast_i` (0 selects RATE_SLOW_HZ, 1 selects RATE_FAST_HZ), and let n be the cycles since the start, taken modulo 2H. Then `offset_o` = min + floor(S·n/H) for n ≤ H, and min + S − floor(S·(n−H)/H) otherwise.
- R7: `phase_up_o` is 1 exactly while n < H, which is the rising half. It is 0 during the falling half.
- R8: `wrap_o` pulses for one cycle each time n returns to 0 after a full period. In that cycle `offset_o` is at the minimum.
- R9: Changes to `down_i`, `dev_code_i` and `fast_i` during a period have no effect until the next return to the minimum. At that point the new minimum appears.
- R10: Between two consecutive cycles of one period, `offset_o` changes by at most ceil(S/H).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low holds the offset at zero |
| down_i | input | 1 | Profile select: 0 centred, 1 downward |
| dev_code_i | input | 5 | Deviation code, in steps of 0.125 % (centred) or 0.25 % (downward) |
| fast_i | input | 1 | Rate select: 0 slow (about 32 kHz), 1 fast (about 120 kHz) |
| offset_o | output | 17 | Signed offset in ppm |
| phase_up_o | output | 1 | High during the rising half of the triangle |
| wrap_o | output | 1 | One-cycle strobe when the triangle returns to its minimum |

## Verification
A wrong accumulator remainder or carry shows up within one half-period as an offset that drifts away from floor(S·n/H). The clearest sign is a peak that misses the exact maximum at tick H. A wrong tick counter or direction flag moves the peak, the phase edge or the wrap strobe by whole cycles, and this shows up by the end of the first period. A wrong latch of the settings shows up as a minimum jump in the middle of a period. It also shows up as a new setting appearing anywhere other than the wrap cycle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int OFS_W         = 17;
    localparam int CODE_W        = 5;
    localparam int K_W           = 5;
    localparam int K_MAX         = 16;
    localparam int CNT_W         = 24;
    localparam int CTR_UNIT_PPM  = 1250;
    localparam int SPAN_UNIT_PPM = 2500;

    typedef struct packed {
        logic              active;
        logic              down;
        logic              fast;
        logic [K_W-1:0]    k;
        logic [CNT_W-1:0]  tick;
        logic [OFS_W-1:0]  pos;
        logic [CNT_W-1:0]  err;
        logic              rise;
        logic              wrap;
    } ssc_state_t;
endpackage

// File: rtl/ssc_code_clamp.sv
module ssc_code_clamp
    import ssc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [K_W-1:0]    k_o
);
    always_comb begin
        if (code_i == '0) begin
            k_o = K_W'(1);
        end else if (int'(code_i) > K_MAX) begin
            k_o = K_W'(K_MAX);
        end else begin
            k_o = K_W'(code_i);
        end
    end
endmodule

// File: rtl/ssc_profile_bounds.sv
module ssc_profile_bounds
    import ssc_pkg::*;
(
    input  logic                    down_i,
    input  logic [K_W-1:0]          k_i,
    output logic signed [OFS_W-1:0] min_o,
    output logic signed [OFS_W-1:0] max_o
);
    logic [OFS_W-1:0] unit_mag;
    logic [OFS_W-1:0] mag;

    always_comb begin
        unit_mag = down_i ? OFS_W'(SPAN_UNIT_PPM) : OFS_W'(CTR_UNIT_PPM);
        mag      = OFS_W'(OFS_W'(k_i) * unit_mag);
        min_o    = -$signed(mag);
        max_o    = down_i ? '0 : $signed(mag);
    end
endmodule

// File: rtl/ssc_step_table.sv
module ssc_step_table
    import ssc_pkg::*;
#(
    parameter longint CLK_HZ       = 100_000_000,
    parameter longint RATE_SLOW_HZ = 32_000,
    parameter longint RATE_FAST_HZ = 120_000
) (
    input  logic [K_W-1:0]   k_i,
    input  logic             fast_i,
    output logic [OFS_W-1:0] quot_o,
    output logic [CNT_W-1:0] rem_o,
    output logic [CNT_W-1:0] half_o
);
    localparam longint HALF_SLOW = CLK_HZ / (2 * RATE_SLOW_HZ);
    localparam longint HALF_FAST = CLK_HZ / (2 * RATE_FAST_HZ);

    logic [OFS_W-1:0] q_slow [K_MAX];
    logic [OFS_W-1:0] q_fast [K_MAX];
    logic [CNT_W-1:0] r_slow [K_MAX];
    logic [CNT_W-1:0] r_fast [K_MAX];

    for (genvar i = 0; i < K_MAX; i++) begin : g_code
        localparam longint SPAN = longint'(i + 1) * SPAN_UNIT_PPM;
        assign q_slow[i] = OFS_W'(SPAN / HALF_SLOW);
        assign r_slow[i] = CNT_W'(SPAN % HALF_SLOW);
        assign q_fast[i] = OFS_W'(SPAN / HALF_FAST);
        assign r_fast[i] = CNT_W'(SPAN % HALF_FAST);
    end

    logic [K_W-1:0] idx;

    always_comb begin
        idx    = (k_i == '0) ? '0 : K_W'(k_i - K_W'(1));
        quot_o = fast_i ? q_fast[idx[3:0]] : q_slow[idx[3:0]];
        rem_o  = fast_i ? r_fast[idx[3:0]] : r_slow[idx[3:0]];
        half_o = fast_i ? CNT_W'(HALF_FAST) : CNT_W'(HALF_SLOW);
    end
endmodule

// File: rtl/ssc_dda_step.sv
module ssc_dda_step
    import ssc_pkg::*;
(
    input  logic [CNT_W-1:0] err_i,
    input  logic [OFS_W-1:0] quot_i,
    input  logic [CNT_W-1:0] rem_i,
    input  logic [CNT_W-1:0] half_i,
    output logic [OFS_W-1:0] delta_o,
    output logic [CNT_W-1:0] err_o
);
    logic [CNT_W-1:0] sum;
    logic             carry;

    always_comb begin
        sum     = err_i + rem_i;
        carry   = (sum >= half_i);
        err_o   = carry ? (sum - half_i) : sum;
        delta_o = quot_i + OFS_W'(carry);
    end
endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
    import ssc_pkg::*;
#(
    parameter longint CLK_HZ       = 100_000_000,
    parameter longint RATE_SLOW_HZ = 32_000,
    parameter longint RATE_FAST_HZ = 120_000
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic                    down_i,
    input  logic [4:0]              dev_code_i,
    input  logic                    fast_i,
    output logic signed [16:0]      offset_o,
    output logic                    phase_up_o,
    output logic                    wrap_o
);
    ssc_state_t s_q, s_d;

    logic [K_W-1:0]          k_in;
    logic signed [OFS_W-1:0] min_ofs, max_ofs;
    logic [OFS_W-1:0]        quot;
    logic [CNT_W-1:0]        rem, half;
    logic [OFS_W-1:0]        delta;
    logic [CNT_W-1:0]        err_nx;

    ssc_code_clamp u_clamp (
        .code_i (dev_code_i),
        .k_o    (k_in)
    );

    ssc_profile_bounds u_bounds (
        .down_i (s_q.down),
        .k_i    (s_q.k),
        .min_o  (min_ofs),
        .max_o  (max_ofs)
    );

    ssc_step_table #(
        .CLK_HZ       (CLK_HZ),
        .RATE_SLOW_HZ (RATE_SLOW_HZ),
        .RATE_FAST_HZ (RATE_FAST_HZ)
    ) u_table (
        .k_i    (s_q.k),
        .fast_i (s_q.fast),
        .quot_o (quot),
        .rem_o  (rem),
        .half_o (half)
    );

    ssc_dda_step u_dda (
        .err_i   (s_q.err),
        .quot_i  (quot),
        .rem_i   (rem),
        .half_i  (half),
        .delta_o (delta),
        .err_o   (err_nx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.wrap = 1'b0;
        if (!en_i) begin
            s_d      = '0;
            s_d.rise = 1'b1;
        end else if (!s_q.active) begin
            s_d.active = 1'b1;
            s_d.down   = down_i;
            s_d.fast   = fast_i;
            s_d.k      = k_in;
            s_d.tick   = '0;
            s_d.pos    = '0;
            s_d.err    = '0;
            s_d.rise   = 1'b1;
        end else begin
            s_d.err = err_nx;
            s_d.pos = s_q.rise ? (s_q.pos + delta) : (s_q.pos - delta);
            if (s_q.tick == half - CNT_W'(1)) begin
                s_d.tick = '0;
                s_d.err  = '0;
                if (s_q.rise) begin
                    s_d.rise = 1'b0;
                end else begin
                    s_d.rise = 1'b1;
                    s_d.wrap = 1'b1;
                    s_d.pos  = '0;
                    s_d.down = down_i;
                    s_d.fast = fast_i;
                    s_d.k    = k_in;
                end
            end else begin
                s_d.tick = s_q.tick + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q      <= '0;
            s_q.rise <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign offset_o   = s_q.active ? (min_ofs + $signed(s_q.pos)) : '0;
    assign phase_up_o = s_q.active & s_q.rise;
    assign wrap_o     = s_q.wrap;

    // R1
    idle_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (offset_o == '0 && !phase_up_o && !wrap_o));

    // R3
    band_limit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        s_q.active |-> (offset_o >= min_ofs && offset_o <= max_ofs));

    // R4
    down_ceiling_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.active && s_q.down) |-> offset_o <= 17'sd0);

    // R8
    wrap_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);

    // R8
    wrap_rising_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |-> (phase_up_o && $past(!phase_up_o)));

    // R10
    step_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.active && $past(s_q.active) && !wrap_o) |->
        ((offset_o - $past(offset_o)) <= $signed(quot + OFS_W'(1)) &&
         ($past(offset_o) - offset_o) <= $signed(quot + OFS_W'(1))));
endmodule

// File: tb/sim_ssc_tri_gen.sv
module sim_ssc_tri_gen;
    localparam int HS = 100_000_000 / (2 * 32_000);
    localparam int HF = 100_000_000 / (2 * 120_000);

    typedef struct packed {
        logic       down;
        logic       fast;
        logic [4:0] code;
        int         minv;
        int         span;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 5'd1,  -1250,  2500},
        '{1'b0, 1'b1, 5'd16, -20000, 40000},
        '{1'b1, 1'b0, 5'd16, -40000, 40000},
        '{1'b1, 1'b1, 5'd1,  -2500,  2500},
        '{1'b0, 1'b1, 5'd0,  -1250,  2500},
        '{1'b1, 1'b1, 5'd31, -40000, 40000},
        '{1'b0, 1'b0, 5'd7,  -8750,  17500},
        '{1'b1, 1'b1, 5'd9,  -22500, 22500}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic down = 1'b0;
    logic [4:0] code = 5'd1;
    logic fast = 1'b0;
    logic signed [16:0] offset;
    logic phase_up;
    logic wrap;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ssc_tri_gen u0 (
        .clk_i      (clk),
        .rst_i      (rst),
        .en_i       (en),
        .down_i     (down),
        .dev_code_i (code),
        .fast_i     (fast),
        .offset_o   (offset),
        .phase_up_o (phase_up),
        .wrap_o     (wrap)
    );

    function automatic int exp_pos(int s, int h, int n);
        int tt = n % (2 * h);
        if (tt <= h) return (s * tt) / h;
        return s - (s * (tt - h)) / h;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_run(logic d, logic f, logic [4:0] c);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        down = d; fast = f; code = c; en = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_vec(vec_t v);
        int h = v.fast ? HF : HS;
        int maxstep = (v.span + h - 1) / h;
        int o_bad = 0, o_act = 0, o_exp = 0;
        int p_bad = 0, p_act = 0, p_exp = 0;
        int w_bad = 0, w_act = 0, w_exp = 0;
        int s_big = 0;
        int prev = 0;
        start_run(v.down, v.fast, v.code);
        for (int n = 0; n <= 2 * h + 2; n++) begin
            int tt = n % (2 * h);
            int eo = v.minv + exp_pos(v.span, h, n);
            int ep = (tt < h) ? 1 : 0;
            int ew = (n > 0 && tt == 0) ? 1 : 0;
            if (n > 0) @(negedge clk);
            if (int'(offset) != eo && o_bad == 0) begin o_bad = 1; o_act = int'(offset); o_exp = eo; end
            if (int'(phase_up) != ep && p_bad == 0) begin p_bad = 1; p_act = int'(phase_up); p_exp = ep; end
            if (int'(wrap) != ew && w_bad == 0) begin w_bad = 1; w_act = int'(wrap); w_exp = ew; end
            if (n > 0 && ew == 0) begin
                int df = int'(offset) - prev;
                if (df < 0) df = -df;
                if (df > s_big) s_big = df;
            end
            prev = int'(offset);
        end
        // R2 R3 R4 R5 R6: trajectory and bounds
        chk(o_bad == 0, "R6", "offset trajectory", o_act, o_exp);
        // R7
        chk(p_bad == 0, "R7", "phase", p_act, p_exp);
        // R8
        chk(w_bad == 0, "R8", "wrap strobe", w_act, w_exp);
        // R10
        chk(s_big <= maxstep, "R10", "largest step", s_big, maxstep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        en = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(offset == 0, "R1", "offset in reset", int'(offset), 0);
        chk(phase_up == 1'b0, "R1", "phase in reset", int'(phase_up), 0);
        chk(wrap == 1'b0, "R1", "wrap in reset", int'(wrap), 0);
        rst = 1'b0;
        en = 1'b0;
        @(negedge clk);

        // R3 R4 R5 R6: table walk
        for (int i = 0; i < 8; i++) begin
            run_vec(VECS[i]);
            chk(1'b1, (i == 4 || i == 5) ? "R5" : (VECS[i].down ? "R4" : "R3"), "vector done", i, i);
        end

        // R1 R2: enable drop and restart
        start_run(1'b0, 1'b0, 5'd4);
        repeat (100) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(offset == 0, "R1", "offset after disable", int'(offset), 0);
        chk(phase_up == 1'b0, "R1", "phase after disable", int'(phase_up), 0);
        en = 1'b1;
        @(negedge clk);
        chk(int'(offset) == -5000, "R2", "restart minimum", int'(offset), -5000);
        @(negedge clk);
        chk(int'(offset) == -4994, "R2", "first rising step", int'(offset), -4994);

        // R9: mid-period change waits for wrap
        start_run(1'b1, 1'b1, 5'd2);
        for (int n = 1; n <= 2 * HF + 1; n++) begin
            @(negedge clk);
            if (n == 10) begin code = 5'd8; down = 1'b0; end
            if (n == 200)
                chk(int'(offset) == -5000 + exp_pos(5000, HF, 200), "R9", "old setting kept",
                    int'(offset), -5000 + exp_pos(5000, HF, 200));
            if (n == 2 * HF) begin
                chk(wrap == 1'b1, "R9", "wrap at period end", int'(wrap), 1);
                chk(int'(offset) == -10000, "R9", "new minimum at wrap", int'(offset), -10000);
            end
            if (n == 2 * HF + 1)
                chk(int'(offset) == -10000 + 20000 / HF, "R9", "new slope",
                    int'(offset), -10000 + 20000 / HF);
        end

        // R1: reset in the middle of a run
        repeat (37) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(offset == 0, "R1", "offset after mid-run reset", int'(offset), 0);
        chk(wrap == 1'b0, "R1", "wrap after mid-run reset", int'(wrap), 0);
        rst = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule